// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block takes a variable-length machine instruction as a stream of bytes, one byte per cycle, on a valid/ready input. It splits the stream into instruction fields: leading prefix bytes, a one- or two-byte opcode, an optional addressing byte (ModR/M), an optional scale-index byte (SIB), a displacement and an immediate. How wide the later fields are depends on the bytes that come before them. The opcode picks whether an addressing byte and an immediate exist. The addressing byte picks the scale-index byte and the displacement width. The two size-override prefixes narrow addresses and operands from 32 to 16 bits.

When the last byte of an instruction is accepted, the block emits a one-cycle record. The record holds every field, the collected prefix state and the total byte count. Field contents stay on the outputs until the next record. Two illegal cases are rejected. One is a prefix run that is too long. The other is an instruction longer than the length cap. In either case the block raises an error pulse, drops the offending byte and begins a fresh instruction with the next byte. Opcode attributes come from a small built-in table. Opcode meaning beyond field sizing is not decoded.

Top module: `vlen_insn_parser`

## Requirements
- R1: While rst_n is low (synchronous, active low), out_valid, err_prefix, err_length and in_ready are 0. From the first clock edge after reset, in_ready is 1.
- R2: Prefix bytes set these record fields. F0 sets out_lock. F3 sets out_rep=1 and F2 sets out_rep=2, and the later one wins. Segment bytes set out_seg: 2E=1, 36=2, 3E=3, 26=4, 64=5, 65=6, and the later one wins (0 = none). 67 sets out_asz16. 66 sets out_osz16. out_npfx counts the prefix bytes.
- R3: The record appears with out_valid high for exactly one cycle, starting at the clock edge that accepts the last byte of the instruction. An opcode with no operand fields (for example 90 or C3) completes on its own byte.
- R4: The byte 0F in opcode position sets out_twobyte, and out_opcode then takes the byte that follows.
- R5: An addressing byte follows these opcodes: one-byte 00-3F where bit 2 is 0; 69, 6B, 80-8F, C0, C1, C6, C7, D0-D3, F6, F7, FE and FF; and every two-byte opcode except 0F 80-0F 8F.
- R6: A scale-index byte follows the addressing byte only when mod (bits 7:6) is not 3, r/m (bits 2:0) is 4, and addressing is 32-bit.
- R7: Displacement width in bytes depends on mod. mod 1 gives 1. mod 2 gives 4, or 2 in 16-bit addressing. mod 0 with r/m 5 gives 4, or 2 in 16-bit addressing. Every other case gives 0. The width is reported on out_disp_len.
- R8: Immediate width (out_imm_len) is as follows. It is 1 for one-byte 00-3F with low bits 4, and for 6A, 6B, 70-7F, 80, 82, 83, A8, B0-B7, C0, C1, C6, CD and EB. It is 2 for C2. It is 4, or 2 after 66, for one-byte 00-3F with low bits 5, for 68, 69, 81, A9, B8-BF, C7, E8 and E9, and for 0F 80-0F 8F. Every other opcode has no immediate.
- R9: Displacement and immediate bytes arrive least significant first and are reported zero-extended on out_disp and out_imm.
- R10: A prefix byte arriving when out_npfx would exceed MAX_PREFIX (4) produces a one-cycle err_prefix and no record. The byte is dropped, and the next byte starts a new instruction with all prefix state cleared.
- R11: An instruction may be up to MAX_LEN bytes. The byte that would be number MAX_LEN+1 produces a one-cycle err_length and no record. That byte is dropped, and the next byte starts a new instruction.
- R12: Cycles with in_valid low change no parsing state, whatever is on in_byte, and produce no output pulse.
- R13: out_len equals the number of bytes the instruction used, and consecutive instructions produce records in order with no byte lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_byte carries a byte |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | One-cycle record strobe |
| out_len | output | LEN_W (4) | Total instruction bytes |
| out_npfx | output | NPFX_W (3) | Prefix byte count |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | 0 none, 1 F3, 2 F2 |
| out_seg | output | 3 | Segment override code |
| out_asz16 | output | 1 | 16-bit addressing |
| out_osz16 | output | 1 | 16-bit operands |
| out_twobyte | output | 1 | Escape byte present |
| out_opcode | output | 8 | Opcode byte |
| out_has_modrm | output | 1 | Addressing byte present |
| out_modrm | output | 8 | Addressing byte |
| out_has_sib | output | 1 | Scale-index byte present |
| out_sib | output | 8 | Scale-index byte |
| out_disp_len | output | 3 | Displacement bytes |
| out_disp | output | 32 | Displacement value |
| out_imm_len | output | 3 | Immediate bytes |
| out_imm | output | 32 | Immediate value |
| err_prefix | output | 1 | Too many prefixes, byte dropped |
| err_length | output | 1 | Length cap exceeded, byte dropped |

## Verification
Any wrong internal state shows up at the latest on the next record strobe. Examples are a field width picked one byte off, a field byte counter that is stuck, or prefix state left over from a dropped instruction. Framing faults are worse, because they do not stay inside one instruction. A single mis-sized field moves every later byte into the wrong field, so the following records show the wrong out_len, shifted field contents and an unexpected count of strobes. The scoreboard therefore checks whole record sequences in order, including the instruction that follows each error recovery.

// File: rtl/vlp_pkg.sv
// Shared types for the variable-length instruction parser.
package vlp_pkg;

    localparam int FLD_BYTES = 4;
    localparam int FLD_W     = 8 * FLD_BYTES;
    localparam int FLEN_W    = 3;

    localparam logic [7:0] ESCAPE_BYTE = 8'h0F;

    // Parser position inside an instruction
    typedef enum logic [2:0] {
        ST_PFX, ST_OP2, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
    } pst_t;

    // Prefix classes
    typedef enum logic [2:0] {
        PC_NONE, PC_LOCK, PC_REP, PC_SEG, PC_ASZ, PC_OSZ
    } pcls_t;

    // Assembled instruction record
    typedef struct packed {
        logic              lock;
        logic [1:0]        rep;
        logic [2:0]        seg;
        logic              asz16;
        logic              osz16;
        logic              two;
        logic [7:0]        opcode;
        logic              has_modrm;
        logic [7:0]        modrm;
        logic              has_sib;
        logic [7:0]        sib;
        logic [FLEN_W-1:0] disp_len;
        logic [FLD_W-1:0]  disp;
        logic [FLEN_W-1:0] imm_len;
        logic [FLD_W-1:0]  imm;
    } rec_t;

endpackage

// File: rtl/vlp_prefix_decode.sv
// Classifies one byte as a prefix or not. Purely combinational.
// Assumes: the caller asks only when a prefix is legal (before the opcode).
module vlp_prefix_decode
    import vlp_pkg::*;
(
    input  logic [7:0] code_i,
    output pcls_t      cls_o,
    output logic [1:0] rep_o,
    output logic [2:0] seg_o
);

    // Map byte value to prefix class and payload
    always_comb begin
        cls_o = PC_NONE;
        rep_o = 2'd0;
        seg_o = 3'd0;
        case (code_i)
            8'hF0: cls_o = PC_LOCK;
            8'hF3: begin cls_o = PC_REP; rep_o = 2'd1; end
            8'hF2: begin cls_o = PC_REP; rep_o = 2'd2; end
            8'h2E: begin cls_o = PC_SEG; seg_o = 3'd1; end
            8'h36: begin cls_o = PC_SEG; seg_o = 3'd2; end
            8'h3E: begin cls_o = PC_SEG; seg_o = 3'd3; end
            8'h26: begin cls_o = PC_SEG; seg_o = 3'd4; end
            8'h64: begin cls_o = PC_SEG; seg_o = 3'd5; end
            8'h65: begin cls_o = PC_SEG; seg_o = 3'd6; end
            8'h67: cls_o = PC_ASZ;
            8'h66: cls_o = PC_OSZ;
            default: ;
        endcase
    end

endmodule

// File: rtl/vlp_opcode_attr.sv
// Simplified opcode attribute table: addressing-byte presence and
// immediate width. Combinational. Assumes the operand size is final
// (all prefixes precede the opcode).
module vlp_opcode_attr
    import vlp_pkg::*;
(
    input  logic              two_i,
    input  logic [7:0]        op_i,
    input  logic              osz16_i,
    output logic              modrm_o,
    output logic [FLEN_W-1:0] imm_len_o
);

    logic [FLEN_W-1:0] zlen;
    logic              alu_grp;

    assign zlen    = osz16_i ? FLEN_W'(2) : FLEN_W'(4);
    assign alu_grp = (op_i[7:6] == 2'b00);

    // Look up attributes by opcode pattern
    always_comb begin
        modrm_o   = 1'b0;
        imm_len_o = '0;
        if (two_i) begin
            if (op_i[7:4] == 4'h8) imm_len_o = zlen;
            else                   modrm_o   = 1'b1;
        end else begin
            if (alu_grp && !op_i[2])            modrm_o   = 1'b1;
            if (alu_grp && op_i[2:0] == 3'd4)   imm_len_o = FLEN_W'(1);
            if (alu_grp && op_i[2:0] == 3'd5)   imm_len_o = zlen;
            if (op_i[7:4] == 4'h8)              modrm_o   = 1'b1;
            if (op_i[7:4] == 4'h7)              imm_len_o = FLEN_W'(1);
            if (op_i[7:3] == 5'b10110)          imm_len_o = FLEN_W'(1);
            if (op_i[7:3] == 5'b10111)          imm_len_o = zlen;
            case (op_i)
                8'h80, 8'h82, 8'h83, 8'h6A, 8'hA8, 8'hCD, 8'hEB:
                    imm_len_o = FLEN_W'(1);
                8'h81, 8'h68, 8'hA9, 8'hE8, 8'hE9:
                    imm_len_o = zlen;
                8'h6B, 8'hC0, 8'hC1, 8'hC6:
                    begin modrm_o = 1'b1; imm_len_o = FLEN_W'(1); end
                8'h69, 8'hC7:
                    begin modrm_o = 1'b1; imm_len_o = zlen; end
                8'hC2:
                    imm_len_o = FLEN_W'(2);
                8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hF6, 8'hF7, 8'hFE, 8'hFF:
                    modrm_o = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vlp_modrm_sizer.sv
// Derives scale-index presence and displacement width from the
// addressing byte's mod and r/m fields. Combinational.
module vlp_modrm_sizer
    import vlp_pkg::*;
(
    input  logic [1:0]        mod_i,
    input  logic [2:0]        rm_i,
    input  logic              asz16_i,
    output logic              sib_o,
    output logic [FLEN_W-1:0] disp_len_o
);

    logic [FLEN_W-1:0] awide;

    assign awide = asz16_i ? FLEN_W'(2) : FLEN_W'(4);

    // Scale-index byte only in 32-bit memory forms with r/m 4
    assign sib_o = !asz16_i && (mod_i != 2'd3) && (rm_i == 3'd4);

    // Displacement width from mod (plus the r/m 5 direct form)
    always_comb begin
        case (mod_i)
            2'd1:    disp_len_o = FLEN_W'(1);
            2'd2:    disp_len_o = awide;
            2'd0:    disp_len_o = (rm_i == 3'd5) ? awide : '0;
            default: disp_len_o = '0;
        endcase
    end

endmodule

// File: rtl/vlen_insn_parser.sv
// Byte-serial instruction field extractor. Accepts one byte per cycle,
// builds a field record and emits it on the last byte. Drops the byte
// and restarts on a prefix overrun or a length overrun.
// Assumes: one instruction after another, no gap in framing.
module vlen_insn_parser
    import vlp_pkg::*;
#(
    parameter  int MAX_PREFIX = 4,
    parameter  int MAX_LEN    = 15,
    localparam int LEN_W      = $clog2(MAX_LEN + 1),
    localparam int NPFX_W     = $clog2(MAX_PREFIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [LEN_W-1:0]  out_len,
    output logic [NPFX_W-1:0] out_npfx,
    output logic              out_lock,
    output logic [1:0]        out_rep,
    output logic [2:0]        out_seg,
    output logic              out_asz16,
    output logic              out_osz16,
    output logic              out_twobyte,
    output logic [7:0]        out_opcode,
    output logic              out_has_modrm,
    output logic [7:0]        out_modrm,
    output logic              out_has_sib,
    output logic [7:0]        out_sib,
    output logic [2:0]        out_disp_len,
    output logic [31:0]       out_disp,
    output logic [2:0]        out_imm_len,
    output logic [31:0]       out_imm,
    output logic              err_prefix,
    output logic              err_length
);

    localparam logic [LEN_W-1:0]  LEN_CAP  = LEN_W'(MAX_LEN);
    localparam logic [NPFX_W-1:0] NPFX_CAP = NPFX_W'(MAX_PREFIX);

    pst_t              st, nst;
    rec_t              cur, nxt, out_rec;
    logic [LEN_W-1:0]  cnt;
    logic [NPFX_W-1:0] npfx, nnpfx;
    logic [1:0]        fidx, nidx;
    logic              accept, done, perr, lerr;

    pcls_t             p_cls;
    logic [1:0]        p_rep;
    logic [2:0]        p_seg;
    logic              a_modrm;
    logic [FLEN_W-1:0] a_imm;
    logic              s_sib;
    logic [FLEN_W-1:0] s_disp;

    assign accept = in_valid && in_ready;

    vlp_prefix_decode u_pfx (
        .code_i (in_byte),
        .cls_o  (p_cls),
        .rep_o  (p_rep),
        .seg_o  (p_seg)
    );

    vlp_opcode_attr u_attr (
        .two_i     (st == ST_OP2),
        .op_i      (in_byte),
        .osz16_i   (cur.osz16),
        .modrm_o   (a_modrm),
        .imm_len_o (a_imm)
    );

    vlp_modrm_sizer u_size (
        .mod_i      (in_byte[7:6]),
        .rm_i       (in_byte[2:0]),
        .asz16_i    (cur.asz16),
        .sib_o      (s_sib),
        .disp_len_o (s_disp)
    );

    // Next record contents and parser position for the current byte
    always_comb begin
        nxt   = cur;
        nst   = st;
        nidx  = fidx;
        nnpfx = npfx;
        done  = 1'b0;
        perr  = 1'b0;
        lerr  = 1'b0;
        case (st)
            ST_PFX: begin
                if (p_cls != PC_NONE) begin
                    if (npfx == NPFX_CAP) begin
                        perr = 1'b1;
                    end else begin
                        nnpfx = npfx + NPFX_W'(1);
                        case (p_cls)
                            PC_LOCK: nxt.lock  = 1'b1;
                            PC_REP:  nxt.rep   = p_rep;
                            PC_SEG:  nxt.seg   = p_seg;
                            PC_ASZ:  nxt.asz16 = 1'b1;
                            PC_OSZ:  nxt.osz16 = 1'b1;
                            default: ;
                        endcase
                    end
                end else if (in_byte == ESCAPE_BYTE) begin
                    nxt.two = 1'b1;
                    nst     = ST_OP2;
                end else begin
                    nxt.opcode    = in_byte;
                    nxt.has_modrm = a_modrm;
                    nxt.imm_len   = a_imm;
                    if (a_modrm)           nst  = ST_MODRM;
                    else if (a_imm != '0)  nst  = ST_IMM;
                    else                   done = 1'b1;
                end
            end
            ST_OP2: begin
                nxt.opcode    = in_byte;
                nxt.has_modrm = a_modrm;
                nxt.imm_len   = a_imm;
                if (a_modrm)           nst  = ST_MODRM;
                else if (a_imm != '0)  nst  = ST_IMM;
                else                   done = 1'b1;
            end
            ST_MODRM: begin
                nxt.modrm    = in_byte;
                nxt.has_sib  = s_sib;
                nxt.disp_len = s_disp;
                if (s_sib)                  nst  = ST_SIB;
                else if (s_disp != '0)      nst  = ST_DISP;
                else if (cur.imm_len != '0) nst  = ST_IMM;
                else                        done = 1'b1;
            end
            ST_SIB: begin
                nxt.sib = in_byte;
                if (cur.disp_len != '0)     nst  = ST_DISP;
                else if (cur.imm_len != '0) nst  = ST_IMM;
                else                        done = 1'b1;
            end
            ST_DISP: begin
                nxt.disp[{fidx, 3'b000} +: 8] = in_byte;
                if ({1'b0, fidx} + 3'd1 == cur.disp_len) begin
                    nidx = '0;
                    if (cur.imm_len != '0) nst  = ST_IMM;
                    else                   done = 1'b1;
                end else begin
                    nidx = fidx + 2'd1;
                end
            end
            ST_IMM: begin
                nxt.imm[{fidx, 3'b000} +: 8] = in_byte;
                if ({1'b0, fidx} + 3'd1 == cur.imm_len) begin
                    nidx = '0;
                    done = 1'b1;
                end else begin
                    nidx = fidx + 2'd1;
                end
            end
            default: nst = ST_PFX;
        endcase
        if (cnt == LEN_CAP) begin
            lerr = 1'b1;
            perr = 1'b0;
            done = 1'b0;
        end
    end

    // Parser state, record capture and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_PFX;
            cur        <= '0;
            cnt        <= '0;
            npfx       <= '0;
            fidx       <= '0;
            in_ready   <= 1'b0;
            out_valid  <= 1'b0;
            out_rec    <= '0;
            out_len    <= '0;
            out_npfx   <= '0;
            err_prefix <= 1'b0;
            err_length <= 1'b0;
        end else begin
            in_ready   <= 1'b1;
            out_valid  <= 1'b0;
            err_prefix <= 1'b0;
            err_length <= 1'b0;
            if (accept) begin
                if (perr || lerr || done) begin
                    st   <= ST_PFX;
                    cur  <= '0;
                    cnt  <= '0;
                    npfx <= '0;
                    fidx <= '0;
                end else begin
                    st   <= nst;
                    cur  <= nxt;
                    cnt  <= cnt + LEN_W'(1);
                    npfx <= nnpfx;
                    fidx <= nidx;
                end
                err_prefix <= perr;
                err_length <= lerr;
                if (done) begin
                    out_valid <= 1'b1;
                    out_rec   <= nxt;
                    out_len   <= cnt + LEN_W'(1);
                    out_npfx  <= nnpfx;
                end
            end
        end
    end

    assign out_lock      = out_rec.lock;
    assign out_rep       = out_rec.rep;
    assign out_seg       = out_rec.seg;
    assign out_asz16     = out_rec.asz16;
    assign out_osz16     = out_rec.osz16;
    assign out_twobyte   = out_rec.two;
    assign out_opcode    = out_rec.opcode;
    assign out_has_modrm = out_rec.has_modrm;
    assign out_modrm     = out_rec.modrm;
    assign out_has_sib   = out_rec.has_sib;
    assign out_sib       = out_rec.sib;
    assign out_disp_len  = out_rec.disp_len;
    assign out_disp      = out_rec.disp;
    assign out_imm_len   = out_rec.imm_len;
    assign out_imm       = out_rec.imm;

    // R10/R11: a strobe is either a record or one error, never both
    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, err_prefix, err_length}));

    // R12: no accepted byte, no strobe on the next cycle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid && !err_prefix && !err_length);

    // R6: scale-index byte only under the mod/rm/address-size rule
    a_r6_sib_rule: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_has_sib |-> out_has_modrm && out_modrm[7:6] != 2'd3
            && out_modrm[2:0] == 3'd4 && !out_asz16);

    // R7: displacement only with an addressing byte, legal widths only
    a_r7_disp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_has_modrm || out_disp_len == 3'd0)
            && (out_disp_len inside {3'd0, 3'd1, 3'd2, 3'd4}));

    // R8: immediate width is one of the legal values
    a_r8_imm_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_imm_len inside {3'd0, 3'd1, 3'd2, 3'd4});

    // R11: no record longer than the cap
    a_r11_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len <= LEN_CAP);

    // R13: length covers at least prefixes plus opcode bytes
    a_r13_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(out_len) >= int'(out_npfx) + 1 + int'(out_twobyte));

    // R2: prefix count never exceeds the limit
    a_r2_npfx_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_npfx <= NPFX_CAP);

endmodule

// File: tb/sim_vlen_insn_parser.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected records and errors, the
// monitor compares each output strobe against the queue head.
module sim_vlen_insn_parser;

    localparam int TB_MAX_LEN = 13;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_byte;
    logic        out_valid;
    logic [3:0]  out_len;
    logic [2:0]  out_npfx;
    logic        out_lock;
    logic [1:0]  out_rep;
    logic [2:0]  out_seg;
    logic        out_asz16, out_osz16, out_twobyte;
    logic [7:0]  out_opcode;
    logic        out_has_modrm;
    logic [7:0]  out_modrm;
    logic        out_has_sib;
    logic [7:0]  out_sib;
    logic [2:0]  out_disp_len;
    logic [31:0] out_disp;
    logic [2:0]  out_imm_len;
    logic [31:0] out_imm;
    logic        err_prefix, err_length;

    always #2 clk = ~clk;

    vlen_insn_parser #(.MAX_PREFIX(4), .MAX_LEN(TB_MAX_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .out_valid(out_valid), .out_len(out_len),
        .out_npfx(out_npfx), .out_lock(out_lock), .out_rep(out_rep),
        .out_seg(out_seg), .out_asz16(out_asz16), .out_osz16(out_osz16),
        .out_twobyte(out_twobyte), .out_opcode(out_opcode),
        .out_has_modrm(out_has_modrm), .out_modrm(out_modrm),
        .out_has_sib(out_has_sib), .out_sib(out_sib),
        .out_disp_len(out_disp_len), .out_disp(out_disp),
        .out_imm_len(out_imm_len), .out_imm(out_imm),
        .err_prefix(err_prefix), .err_length(err_length)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 0 record, 1 prefix error, 2 length error
        logic [3:0]  len;
        logic [2:0]  npfx;
        logic        lock;
        logic [1:0]  rep;
        logic [2:0]  seg;
        logic        asz, osz, two;
        logic [7:0]  opc;
        logic        hm;
        logic [7:0]  modrm;
        logic        hs;
        logic [7:0]  sib;
        logic [2:0]  dl;
        logic [31:0] disp;
        logic [2:0]  il;
        logic [31:0] imm;
    } exp_t;

    exp_t       expq[$];
    int         rqq[$];
    logic [7:0] bq[$];
    exp_t       e;
    int         checks = 0;
    int         errors = 0;
    bit         gaps = 1'b0;
    bit         finished = 1'b0;

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic push_exp(input int rq);
        expq.push_back(e);
        rqq.push_back(rq);
    endtask

    task automatic put(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bq.push_back(v[i*8 +: 8]);
    endtask

    // Driver: one byte per cycle, optional idle cycles carrying junk
    task automatic feed();
        while (bq.size() != 0) begin
            in_byte  = bq.pop_front();
            in_valid = 1'b1;
            @(negedge clk);
            if (gaps) begin
                in_valid = 1'b0;
                in_byte  = 8'hF0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    // Monitor: compare every strobe with the scoreboard head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && (out_valid || err_prefix || err_length)) begin
            exp_t a;
            a = '0;
            a.kind = out_valid ? 2'd0 : (err_prefix ? 2'd1 : 2'd2);
            if (out_valid) begin
                a.len = out_len;  a.npfx = out_npfx; a.lock = out_lock;
                a.rep = out_rep;  a.seg = out_seg;   a.asz = out_asz16;
                a.osz = out_osz16; a.two = out_twobyte; a.opc = out_opcode;
                a.hm = out_has_modrm; a.modrm = out_modrm;
                a.hs = out_has_sib;   a.sib = out_sib;
                a.dl = out_disp_len;  a.disp = out_disp;
                a.il = out_imm_len;   a.imm = out_imm;
            end
            if (expq.size() == 0) begin
                // R13: no strobe beyond the expected sequence
                chk(1'b0, 13, "unexpected strobe", 64'(a.kind), 64'd3);
            end else begin
                exp_t x;
                int   rq;
                x  = expq.pop_front();
                rq = rqq.pop_front();
                checks++;
                if (a !== x) begin
                    errors++;
                    $display("FAIL R%0d record: actual %h expected %h", rq, a, x);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_byte  = 8'h00;
        repeat (3) @(negedge clk);
        // R1: quiet outputs and not ready in reset
        chk(!out_valid && !err_prefix && !err_length && !in_ready, 1,
            "reset outputs", {out_valid, err_prefix, err_length, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, 1, "ready after reset", 64'(in_ready), 64'd1);

        // R3: single-byte opcode, strobe right after its byte
        e = '0; e.len = 1; e.opc = 8'h90; push_exp(3);
        put(64'h90, 1); feed();
        chk(out_valid === 1'b1 && out_len == 4'd1, 3, "strobe timing",
            {out_valid, out_len}, {1'b1, 4'd1});
        @(negedge clk);
        chk(out_valid === 1'b0, 3, "strobe one cycle", 64'(out_valid), 64'd0);

        // R2: four prefixes of different classes
        e = '0; e.len = 5; e.npfx = 4; e.lock = 1; e.rep = 1; e.seg = 1;
        e.osz = 1; e.opc = 8'h90; push_exp(2);
        put(64'hF0F32E6690, 5);
        // R2: later repeat and segment prefix win
        e = '0; e.len = 5; e.npfx = 4; e.rep = 2; e.seg = 5; e.opc = 8'hC3;
        push_exp(2);
        put(64'hF3F26564C3, 5);
        e = '0; e.len = 5; e.npfx = 4; e.seg = 4; e.asz = 1; e.opc = 8'h90;
        push_exp(2);
        put(64'h363E266790, 5);
        // R4 R5: two-byte opcode with addressing byte
        e = '0; e.len = 3; e.two = 1; e.opc = 8'hAF; e.hm = 1; e.modrm = 8'hC8;
        push_exp(4);
        put(64'h0FAFC8, 3);
        // R4 R8: two-byte branch with 32-bit immediate
        e = '0; e.len = 6; e.two = 1; e.opc = 8'h84; e.il = 4; e.imm = 32'h12345678;
        push_exp(4);
        put(64'h0F8478563412, 6);
        // R6 R7 R9: scale-index byte plus 8-bit displacement
        e = '0; e.len = 4; e.opc = 8'h8B; e.hm = 1; e.modrm = 8'h44; e.hs = 1;
        e.sib = 8'h24; e.dl = 1; e.disp = 32'h08; push_exp(6);
        put(64'h8B442408, 4);
        // R7 R9: mod 2, 32-bit displacement
        e = '0; e.len = 6; e.opc = 8'h8B; e.hm = 1; e.modrm = 8'h80; e.dl = 4;
        e.disp = 32'hDEADBEEF; push_exp(7);
        put(64'h8B80EFBEADDE, 6);
        // R7: mod 0 r/m 5 direct form
        e = '0; e.len = 6; e.opc = 8'h8B; e.hm = 1; e.modrm = 8'h05; e.dl = 4;
        e.disp = 32'h11223344; push_exp(7);
        put(64'h8B0544332211, 6);
        // R6 R7: 16-bit addressing, no scale-index, 2-byte displacement
        e = '0; e.len = 5; e.npfx = 1; e.asz = 1; e.opc = 8'h8B; e.hm = 1;
        e.modrm = 8'h84; e.dl = 2; e.disp = 32'h1234; push_exp(6);
        put(64'h678B843412, 5);
        e = '0; e.len = 5; e.npfx = 1; e.asz = 1; e.opc = 8'h8B; e.hm = 1;
        e.modrm = 8'h05; e.dl = 2; e.disp = 32'h1122; push_exp(7);
        put(64'h678B052211, 5);
        // R6: register form with r/m 4 has no scale-index byte
        e = '0; e.len = 2; e.opc = 8'h8B; e.hm = 1; e.modrm = 8'hCC; push_exp(6);
        put(64'h8BCC, 2);
        // R8: operand-size prefix shrinks the immediate
        e = '0; e.len = 4; e.npfx = 1; e.osz = 1; e.opc = 8'hB8; e.il = 2;
        e.imm = 32'hABCD; push_exp(8);
        put(64'h66B8CDAB, 4);
        // R5 R8: addressing byte and 32-bit immediate
        e = '0; e.len = 6; e.opc = 8'h81; e.hm = 1; e.modrm = 8'hC1; e.il = 4;
        e.imm = 32'h12345678; push_exp(8);
        put(64'h81C178563412, 6);
        // R8: 8-bit immediate, and fixed 16-bit immediate despite 66
        e = '0; e.len = 2; e.opc = 8'h04; e.il = 1; e.imm = 32'h7F; push_exp(8);
        put(64'h047F, 2);
        e = '0; e.len = 4; e.npfx = 1; e.osz = 1; e.opc = 8'hC2; e.il = 2;
        e.imm = 32'h0008; push_exp(8);
        put(64'h66C20800, 4);
        // R10: fifth prefix rejected, next byte starts clean
        e = '0; e.kind = 1; push_exp(10);
        e = '0; e.len = 1; e.opc = 8'h90; push_exp(10);
        put(64'hF0F0F0F0F090, 6);
        // R11: exactly MAX_LEN bytes accepted
        e = '0; e.len = 13; e.npfx = 2; e.lock = 1; e.seg = 1; e.opc = 8'h81;
        e.hm = 1; e.modrm = 8'h84; e.hs = 1; e.sib = 8'h00; e.dl = 4;
        e.disp = 32'h44332211; e.il = 4; e.imm = 32'hD4C3B2A1; push_exp(11);
        put(64'h2EF081840011, 6); put(64'h223344A1B2C3D4, 7);
        // R11: byte MAX_LEN+1 rejected, following byte is a new instruction
        e = '0; e.kind = 2; push_exp(11);
        e = '0; e.len = 1; e.opc = 8'h90; push_exp(11);
        put(64'hF0F32E3E818400, 7); put(64'h1122334455667790, 8);
        // R13: back-to-back single-byte instructions
        e = '0; e.len = 1; e.opc = 8'h90; push_exp(13);
        e = '0; e.len = 1; e.opc = 8'hC3; push_exp(13);
        put(64'h90C3, 2);
        feed();
        repeat (3) @(negedge clk);

        // R12: idle cycles with junk bytes change nothing
        gaps = 1'b1;
        e = '0; e.len = 4; e.opc = 8'h8B; e.hm = 1; e.modrm = 8'h44; e.hs = 1;
        e.sib = 8'h24; e.dl = 1; e.disp = 32'h08; push_exp(12);
        put(64'h8B442408, 4);
        e = '0; e.len = 6; e.opc = 8'h81; e.hm = 1; e.modrm = 8'hC1; e.il = 4;
        e.imm = 32'h12345678; push_exp(12);
        put(64'h81C178563412, 6);
        feed();
        gaps = 1'b0;
        repeat (4) @(negedge clk);

        // R13: every expected strobe arrived
        chk(expq.size() == 0, 13, "pending items", 64'(expq.size()), 64'd0);
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule